// File: doc/BRIEF.md
# Prefetch Line Buffer Tag Store with Protected Round-Robin Replacement

This block keeps the tags of a small set of prefetched cache lines. Any line may sit in any slot. A lookup compares the requested line address with every stored tag in parallel and, in the same cycle, answers hit or miss with the index of the matching slot. A fill names a line that has just been prefetched. The block answers with the slot that will receive it, and it commits that slot at the next rising clock edge.

Replacement is a cheap stand-in for least-recently-used. A round-robin pointer walks over the slots, but it passes over any slot that belongs to the small list of most recently touched lines. Empty slots are always used before a valid line is evicted. The line data lives elsewhere and is indexed by the slot numbers this block returns.

Top module: `pfb_rrmru_buf`

## Requirements
- R1: After reset every slot is empty and every lookup misses. The first fill is placed in slot 0.
- R2: The tag is the line address with the low 7 bits dropped, because lines are 128 bytes. A lookup whose tag matches a valid slot asserts hit in the same cycle and returns that slot's index, whatever the low 7 bits are.
- R3: While any slot is empty, a fill that matches no valid slot takes the empty slot with the lowest index.
- R4: A fill whose tag already matches a valid slot returns that slot and allocates nothing. The next new fill still goes to the next empty slot.
- R5: When all slots are valid, a new fill evicts the first slot at or after the round-robin pointer, in increasing index with wrap from 14 to 0, that is not among the three most recently touched slots.
- R6: After an eviction the pointer moves to the slot after the victim, wrapping from 14 to 0. Filling an empty slot leaves the pointer unchanged.
- R7: A lookup hit and a fill both make their slot the most recently touched one. Within a cycle the fill counts as later than the lookup. A line that a lookup has recently hit is therefore protected from eviction.
- R8: A lookup and a fill in the same cycle: the lookup sees the contents from before that fill.
- R9: An evicted line's tag misses afterwards. While lookup valid is low, hit is low and the index is 0. On a miss the index is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup byte address |
| lk_hit_o | output | 1 | Lookup matched a valid slot |
| lk_idx_o | output | 4 | Index of the matching slot, 0 on miss |
| fl_valid_i | input | 1 | Fill request for a prefetched line |
| fl_addr_i | input | 32 | Fill byte address |
| fl_slot_o | output | 4 | Slot that the fill uses |

## Verification
A corrupted recency list shows up at fl_slot_o only once the buffer is full, on the next eviction: a protected line gets chosen, or a slot is skipped that should not be. A round-robin pointer left at the wrong place after an eviction shows up on the following eviction. A bad valid bit or tag shows up at once as a wrong lk_hit_o or lk_idx_o. It can also show up as a fill landing on an occupied slot while the buffer still has empty ones. The bench runs a reference model alongside the design every cycle, so each of these faults is reported within one eviction of its cause.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int unsigned PFB_SLOTS      = 15;
  localparam int unsigned PFB_MRU_DEPTH  = 3;
  localparam int unsigned PFB_ADDR_W     = 32;
  localparam int unsigned PFB_LINE_BYTES = 128;

  function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/pfb_tag_store.sv
module pfb_tag_store #(
  parameter int unsigned SLOTS = 15,
  parameter int unsigned TAG_W = 25,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [TAG_W-1:0] fl_tag_i,
  output logic [SLOTS-1:0] valid_o,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic             fl_hit_o,
  output logic [IDX_W-1:0] fl_idx_o
);
  logic [SLOTS-1:0]            valid_q;
  logic [SLOTS-1:0][TAG_W-1:0] tag_q;
  logic [SLOTS-1:0]            lk_match, fl_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (wr_en_i) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (wr_idx_i == IDX_W'(s)) begin
          valid_q[s] <= 1'b1;
          tag_q[s]   <= wr_tag_i;
        end
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_tag_i);
    assign fl_match[g] = valid_q[g] && (tag_q[g] == fl_tag_i);
  end

  always_comb begin
    lk_idx_o = '0;
    fl_idx_o = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (lk_match[s]) lk_idx_o = IDX_W'(s);
      if (fl_match[s]) fl_idx_o = IDX_W'(s);
    end
  end

  assign lk_hit_o = |lk_match;
  assign fl_hit_o = |fl_match;
  assign valid_o  = valid_q;

  assert_tag_unique_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match) && $onehot0(fl_match));
  assert_write_sets_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)]);
  assert_valid_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_q) != '0 |-> (valid_q & $past(valid_q)) == $past(valid_q));
endmodule

// File: rtl/pfb_mru_track.sv
module pfb_mru_track #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned IDX_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ta_en_i,
  input  logic [IDX_W-1:0]            ta_idx_i,
  input  logic                        tb_en_i,
  input  logic [IDX_W-1:0]            tb_idx_i,
  output logic [DEPTH-1:0][IDX_W-1:0] mru_idx_o,
  output logic [DEPTH-1:0]            mru_vld_o
);
  typedef struct packed {
    logic [DEPTH-1:0]            vld;
    logic [DEPTH-1:0][IDX_W-1:0] idx;
  } mru_list_t;

  mru_list_t cur_q, mid, nxt;

  // move s to the front; entries above its old place shift down by one
  function automatic mru_list_t touch(mru_list_t o, logic [IDX_W-1:0] s);
    mru_list_t n;
    int p;
    p = DEPTH;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (o.vld[k] && o.idx[k] == s) p = k;
    n = o;
    n.idx[0] = s;
    n.vld[0] = 1'b1;
    for (int k = 1; k < DEPTH; k++) begin
      if (k <= p) begin
        n.idx[k] = o.idx[k-1];
        n.vld[k] = o.vld[k-1];
      end
    end
    return n;
  endfunction

  always_comb begin
    mid = ta_en_i ? touch(cur_q, ta_idx_i) : cur_q;
    nxt = tb_en_i ? touch(mid, tb_idx_i) : mid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= nxt;
  end

  assign mru_idx_o = cur_q.idx;
  assign mru_vld_o = cur_q.vld;

  assert_fill_is_newest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_en_i |=> mru_vld_o[0] && mru_idx_o[0] == $past(tb_idx_i));
  assert_hit_is_newest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ta_en_i && !tb_en_i) |=> mru_vld_o[0] && mru_idx_o[0] == $past(ta_idx_i));
endmodule

// File: rtl/pfb_victim_sel.sv
module pfb_victim_sel
  import pfb_pkg::*;
#(
  parameter int unsigned SLOTS = 15,
  parameter int unsigned DEPTH = 3,
  parameter int unsigned IDX_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SLOTS-1:0]            valid_i,
  input  logic [DEPTH-1:0][IDX_W-1:0] mru_idx_i,
  input  logic [DEPTH-1:0]            mru_vld_i,
  input  logic                        adv_i,
  output logic                        free_o,
  output logic [IDX_W-1:0]            free_idx_o,
  output logic [IDX_W-1:0]            victim_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [SLOTS-1:0] blocked;

  always_comb begin
    blocked = '0;
    for (int j = 0; j < SLOTS; j++)
      for (int m = 0; m < DEPTH; m++)
        if (mru_vld_i[m] && mru_idx_i[m] == IDX_W'(j)) blocked[j] = 1'b1;
  end

  always_comb begin
    free_idx_o = '0;
    for (int j = SLOTS - 1; j >= 0; j--)
      if (!valid_i[j]) free_idx_o = IDX_W'(j);
  end
  assign free_o = ~&valid_i;

  always_comb begin
    logic found;
    int   j;
    found    = 1'b0;
    victim_o = ptr_q;
    for (int k = 0; k < SLOTS; k++) begin
      j = int'(ptr_q) + k;
      if (j >= int'(SLOTS)) j = j - int'(SLOTS);
      if (!found && !blocked[j]) begin
        victim_o = IDX_W'(j);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= IDX_W'(wrap_next(int'(victim_o), SLOTS));
  end

  for (genvar m = 0; m < DEPTH; m++) begin : g_chk
    assert_victim_not_recent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i |-> !(mru_vld_i[m] && mru_idx_i[m] == victim_o));
  end
  assert_ptr_follows_victim_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_q == IDX_W'(wrap_next(int'($past(victim_o)), SLOTS)));
  assert_ptr_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q));
  assert_victim_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(victim_o) < int'(SLOTS));
endmodule

// File: rtl/pfb_rrmru_buf.sv
module pfb_rrmru_buf
  import pfb_pkg::*;
#(
  parameter int unsigned SLOTS      = PFB_SLOTS,
  parameter int unsigned MRU_DEPTH  = PFB_MRU_DEPTH,
  parameter int unsigned ADDR_W     = PFB_ADDR_W,
  parameter int unsigned LINE_BYTES = PFB_LINE_BYTES,
  localparam int unsigned IDX_W     = $clog2(SLOTS),
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W     = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  input  logic              fl_valid_i,
  input  logic [ADDR_W-1:0] fl_addr_i,
  output logic [IDX_W-1:0]  fl_slot_o
);
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [SLOTS-1:0] valid;
  logic             ts_lk_hit, ts_fl_hit, free, wr_en, adv;
  logic [IDX_W-1:0] ts_lk_idx, ts_fl_idx, free_idx, victim;
  logic [MRU_DEPTH-1:0][IDX_W-1:0] mru_idx;
  logic [MRU_DEPTH-1:0]            mru_vld;

  assign lk_tag = lk_addr_i[ADDR_W-1:OFS_W];
  assign fl_tag = fl_addr_i[ADDR_W-1:OFS_W];

  pfb_tag_store #(.SLOTS(SLOTS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk_i, .rst_ni,
    .wr_en_i (wr_en),    .wr_idx_i (fl_slot_o), .wr_tag_i (fl_tag),
    .lk_tag_i(lk_tag),   .fl_tag_i (fl_tag),    .valid_o  (valid),
    .lk_hit_o(ts_lk_hit), .lk_idx_o(ts_lk_idx),
    .fl_hit_o(ts_fl_hit), .fl_idx_o(ts_fl_idx)
  );

  pfb_mru_track #(.DEPTH(MRU_DEPTH), .IDX_W(IDX_W)) u_mru (
    .clk_i, .rst_ni,
    .ta_en_i (lk_hit_o),   .ta_idx_i(lk_idx_o),
    .tb_en_i (fl_valid_i), .tb_idx_i(fl_slot_o),
    .mru_idx_o(mru_idx),   .mru_vld_o(mru_vld)
  );

  pfb_victim_sel #(.SLOTS(SLOTS), .DEPTH(MRU_DEPTH), .IDX_W(IDX_W)) u_vict (
    .clk_i, .rst_ni,
    .valid_i(valid), .mru_idx_i(mru_idx), .mru_vld_i(mru_vld),
    .adv_i(adv), .free_o(free), .free_idx_o(free_idx), .victim_o(victim)
  );

  assign lk_hit_o  = lk_valid_i && ts_lk_hit;
  assign lk_idx_o  = lk_hit_o ? ts_lk_idx : '0;
  assign wr_en     = fl_valid_i && !ts_fl_hit;
  assign adv       = wr_en && !free;
  assign fl_slot_o = ts_fl_hit ? ts_fl_idx : (free ? free_idx : victim);

  assert_fill_visible_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_valid_i && lk_valid_i && lk_tag == fl_tag) |=> u_tags.fl_hit_o || !fl_valid_i || fl_tag != $past(fl_tag));
  assert_no_evict_when_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && free) |-> !valid[fl_slot_o]);
endmodule

// File: tb/pfb_rrmru_buf_tb_top.sv
module pfb_rrmru_buf_tb_top;
  localparam int N = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_v = 1'b0, fl_v = 1'b0;
  logic [31:0] lk_a = '0, fl_a = '0;
  logic        lk_hit;
  logic [3:0]  lk_idx, fl_slot;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfb_rrmru_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_v), .lk_addr_i(lk_a), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx),
    .fl_valid_i(fl_v), .fl_addr_i(fl_a), .fl_slot_o(fl_slot)
  );

  typedef struct {
    string req;
    bit    hit;
    int    idx;
    bit    chk_fill;
    int    slot;
  } exp_t;
  exp_t sb_q[$];

  // reference model
  bit m_vld[N];
  int m_tag[N];
  int m_mru[$];
  int m_ptr;

  function automatic void m_reset();
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
    m_mru.delete();
    m_ptr = 0;
  endfunction

  function automatic int m_find(int tag);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == tag) return i;
    return -1;
  endfunction

  function automatic bit m_recent(int s);
    foreach (m_mru[k]) if (m_mru[k] == s) return 1;
    return 0;
  endfunction

  function automatic void m_touch(int s);
    for (int k = m_mru.size() - 1; k >= 0; k--) if (m_mru[k] == s) m_mru.delete(k);
    m_mru.push_front(s);
    if (m_mru.size() > 3) void'(m_mru.pop_back());
  endfunction

  task automatic step(bit lv, logic [31:0] la, bit fv, logic [31:0] fa, string req);
    exp_t e;
    int lh, fh, slot;
    bit full;
    @(negedge clk);
    lk_v = lv; lk_a = la; fl_v = fv; fl_a = fa;
    lh = lv ? m_find(int'(la >> 7)) : -1;
    fh = m_find(int'(fa >> 7));
    full = 1;
    for (int i = 0; i < N; i++) if (!m_vld[i]) full = 0;
    slot = 0;
    if (fh >= 0) slot = fh;
    else if (!full) begin
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
    end else begin
      for (int k = N - 1; k >= 0; k--) if (!m_recent((m_ptr + k) % N)) slot = (m_ptr + k) % N;
    end
    e.req = req; e.hit = (lh >= 0); e.idx = (lh >= 0) ? lh : 0;
    e.chk_fill = fv; e.slot = slot;
    sb_q.push_back(e);
    if (lh >= 0) m_touch(lh);
    if (fv) begin
      if (fh < 0) begin
        m_vld[slot] = 1; m_tag[slot] = int'(fa >> 7);
        if (full) m_ptr = (slot + 1) % N;
      end
      m_touch(slot);
    end
  endtask

  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (lk_hit !== e.hit || (e.hit && int'(lk_idx) != e.idx) || (!e.hit && lk_idx !== 4'd0)) begin
        errors++;
        $display("FAIL %s lookup hit=%0b idx=%0d expected hit=%0b idx=%0d", e.req, lk_hit, lk_idx, e.hit, e.idx);
      end
      if (e.chk_fill) begin
        checks++;
        if (int'(fl_slot) != e.slot) begin
          errors++;
          $display("FAIL %s fill slot=%0d expected %0d", e.req, fl_slot, e.slot);
        end
      end
    end
  end

  function automatic logic [31:0] ln(int k, int ofs);
    return 32'h0001_0000 + 32'(k) * 32'd128 + 32'(ofs);
  endfunction

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset, first fill to slot 0
    step(1, ln(0, 0), 0, '0, "R1");
    step(0, '0, 1, ln(0, 0), "R1");
    // R3: lowest empty slot first
    for (int k = 1; k < N; k++) step(0, '0, 1, ln(k, 0), "R3");
    // R2: low 7 bits ignored
    step(1, ln(7, 127), 0, '0, "R2");
    step(1, ln(0, 64), 0, '0, "R2");
    step(1, ln(14, 1), 0, '0, "R2");
    // R9: lookup valid low gives no hit
    step(0, ln(3, 0), 0, '0, "R9");
    // R4: refill existing line
    step(0, '0, 1, ln(5, 9), "R4");
    // R7: protect slots 0,1,2 then evict
    step(1, ln(0, 0), 0, '0, "R7");
    step(1, ln(1, 0), 0, '0, "R7");
    step(1, ln(2, 0), 0, '0, "R7");
    step(0, '0, 1, ln(100, 0), "R5");
    step(0, '0, 1, ln(101, 0), "R6");
    // R9: evicted lines miss
    step(1, ln(3, 0), 0, '0, "R9");
    step(1, ln(4, 0), 0, '0, "R9");
    // R8: same-cycle lookup and fill of a new line
    step(1, ln(200, 0), 1, ln(200, 0), "R8");
    step(1, ln(200, 5), 0, '0, "R8");
    // R6: run the pointer around past the wrap
    for (int k = 0; k < 20; k++) step(0, '0, 1, ln(300 + k, 0), "R6");
    // R7: fill and lookup in the same cycle on different lines
    step(1, ln(319, 0), 1, ln(400, 0), "R7");
    step(0, '0, 1, ln(401, 0), "R7");
    // mixed random traffic over a small pool
    for (int k = 0; k < 400; k++) begin
      int a, b;
      a = int'($urandom_range(0, 23));
      b = int'($urandom_range(0, 23));
      step(bit'($urandom_range(0, 1)), ln(500 + a, int'($urandom_range(0, 127))),
           bit'($urandom_range(0, 1)), ln(500 + b, int'($urandom_range(0, 127))), "R5");
    end
    // R1: reset clears contents
    @(negedge clk);
    lk_v = 0; fl_v = 0;
    rst_n = 1'b0;
    m_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step(1, ln(500, 0), 1, ln(600, 0), "R1");
    step(0, '0, 0, '0, "R1");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule